// File: doc/BRIEF.md
# Gated Timer/Counter Channel

A single 16-bit timer/counter channel of the kind found next to a small 8-bit processor core. In timer use it advances once per clock while enabled. In counter use it counts falling edges on an external count pin. That pin is resynchronised, then sampled once per machine cycle on a strobe supplied by the core. A falling edge is recognised when one sample is high and the next is low. The count moves one machine cycle after that recognition, which limits the external rate to a quarter of the CPU clock.

Counting is enabled by a run bit. A gate bit can additionally make counting depend on a synchronised external gate pin being high, which is how pulse widths are measured. Three count arrangements are offered: a 13-bit count with a 5-bit prescaler, a plain 16-bit count, and an 8-bit count that reloads from the high byte. Every wrap sets a sticky overflow flag. When enabled, every wrap also flips a toggle output. A write port loads the count; this is also how the reload value is placed in the high byte.

Top module: `gtc_channel`

## Requirements
- R1: After reset the count is 0x0000 and both the overflow flag and the toggle output are 0.
- R2: When the write enable is high, the count takes the write data at the next clock edge, and any increment requested in that cycle is discarded.
- R3: With the select bit (ctl_i[2]) at 0, an enabled channel advances by one step on every clock edge.
- R4: Counting is enabled only while run_i is 1. With the gate bit (ctl_i[3]) at 1, the gate pin must also be high. The gate pin passes through two flops, so it acts three edges after it changes. With the gate bit at 0, the gate pin has no effect.
- R5: Mode ctl_i[1:0]=00 is a 13-bit count. Bits [4:0] of the low byte form a prescaler that carries into the high byte. Bits [7:5] of the low byte stay unchanged. The count wraps when the high byte is 0xFF and the prescaler is 0x1F.
- R6: Mode 01 is a 16-bit count that wraps from 0xFFFF to 0x0000.
- R7: In mode 10 only the low byte counts. When the low byte is 0xFF, the next step loads it from the high byte and counts as a wrap. The high byte never changes in this mode.
- R8: In mode 11 the count holds its value.
- R9: With the select bit at 1, clock ticks do not advance the count. The synchronised pin is sampled only when mc_stb_i is high. A high sample followed by a low sample adds exactly one, and this happens at the strobe after the one that saw the low sample. Pin activity while the strobe is absent adds nothing.
- R10: A wrap sets the overflow flag at the same edge as the wrap. The flag stays set until ovf_clr_i is applied. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R11: Each wrap flips tog_o when tog_en_i is 1. When tog_en_i is 0, tog_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_stb_i | input | 1 | Machine-cycle strobe, one clock per machine cycle |
| run_i | input | 1 | Run bit |
| ctl_i | input | 4 | Control nibble {gate, select, M1, M0} |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| tog_en_i | input | 1 | Enable toggling of tog_o on wrap |
| ovf_clr_i | input | 1 | Clear for the overflow flag |
| wr_en_i | input | 1 | Count load enable |
| wr_data_i | input | 16 | Count load value {high byte, low byte} |
| cnt_o | output | 16 | Count {high byte, low byte} |
| ovf_o | output | 1 | Sticky overflow flag |
| tog_o | output | 1 | Toggle output |

## Verification
The flag clear requested by software and a wrap produced by the counter can land in the same clock. The bench provokes this by loading 0xFFFF in the 16-bit mode and then, for one cycle, asserting run and ovf_clr_i together. It expects the count at 0x0000, the flag still set and the toggle output flipped. A clear applied later, with the channel stopped, must then drop the flag.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'b00,
    MODE_FULL16  = 2'b01,
    MODE_RELOAD8 = 2'b10,
    MODE_HOLD    = 2'b11
  } gtc_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      ext_sel;
    gtc_mode_e mode;
  } gtc_ctl_t;

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/gtc_edge_det.sv
module gtc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic stb_i,
  output logic inc_o
);

  logic pin_s;
  logic smp_q, smp_d;
  logic fall_q, fall_d;

  gtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_s)
  );

  // A detected fall is held for one machine cycle and released at the next strobe.
  always_comb begin
    smp_d  = smp_q;
    fall_d = fall_q;
    if (stb_i) begin
      smp_d  = pin_s;
      fall_d = smp_q & ~pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      fall_q <= 1'b0;
    end else if (stb_i) begin
      smp_q  <= smp_d;
      fall_q <= fall_d;
    end
  end

  assign inc_o = stb_i & fall_q;

  AST_FALL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o && !(smp_q && !pin_s) |=> !fall_q) else $error("fall reused"); // R9

endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core
  import gtc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [2*BYTE_W-1:0]   wr_data_i,
  input  gtc_mode_e             mode_i,
  input  logic                  tick_i,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic                  wrap_o
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam int UPR_W = BYTE_W - PRE_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] lo, hi;
  logic [PRE_W-1:0]  pre;
  logic              cnt_ld;
  logic              wrap;

  assign lo  = cnt_q[BYTE_W-1:0];
  assign hi  = cnt_q[CNT_W-1:BYTE_W];
  assign pre = lo[PRE_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (wr_en_i) begin
      cnt_d = wr_data_i;
    end else if (tick_i) begin
      unique case (mode_i)
        MODE_PRE13: begin
          if (&pre) begin
            cnt_d = {hi + BYTE_W'(1), lo[BYTE_W-1:PRE_W], {PRE_W{1'b0}}};
            wrap  = &hi;
          end else begin
            cnt_d = {hi, lo[BYTE_W-1:PRE_W], pre + PRE_W'(1)};
          end
        end
        MODE_FULL16: begin
          cnt_d = cnt_q + CNT_W'(1);
          wrap  = &cnt_q;
        end
        MODE_RELOAD8: begin
          if (&lo) begin
            cnt_d = {hi, hi};
            wrap  = 1'b1;
          end else begin
            cnt_d = {hi, lo + BYTE_W'(1)};
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign cnt_ld = wr_en_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;

  AST_RELOAD_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RELOAD8) && !wr_en_i |=> $stable(cnt_q[CNT_W-1:BYTE_W])) else $error("hi moved"); // R7
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOLD) && !wr_en_i |=> $stable(cnt_q)) else $error("mode 3 moved"); // R8
  AST_FULL_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && (mode_i == MODE_FULL16) |=> (cnt_q == '0)) else $error("wrap not zero"); // R6
  AST_PRE13_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PRE13) && !wr_en_i |=> $stable(cnt_q[BYTE_W-1:BYTE_W-UPR_W])) else $error("upper lo moved"); // R5

endmodule

// File: rtl/gtc_channel.sv
module gtc_channel
  import gtc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mc_stb_i,
  input  logic                run_i,
  input  logic [3:0]          ctl_i,
  input  logic                cnt_pin_i,
  input  logic                gate_pin_i,
  input  logic                tog_en_i,
  input  logic                ovf_clr_i,
  input  logic                wr_en_i,
  input  logic [2*BYTE_W-1:0] wr_data_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                ovf_o,
  output logic                tog_o
);

  gtc_ctl_t ctl;
  logic     gate_s;
  logic     ext_inc;
  logic     cnt_en;
  logic     tick;
  logic     wrap;
  logic     ovf_q, ovf_d;
  logic     tog_q, tog_d;

  assign ctl = gtc_ctl_t'(ctl_i);

  gtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (gate_pin_i),
    .q_o  (gate_s)
  );

  gtc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin_i(cnt_pin_i),
    .stb_i(mc_stb_i),
    .inc_o(ext_inc)
  );

  assign cnt_en = run_i & (~ctl.gate_en | gate_s);
  assign tick   = cnt_en & (ctl.ext_sel ? ext_inc : 1'b1);

  gtc_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .mode_i   (ctl.mode),
    .tick_i   (tick),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap)
  );

  always_comb begin
    ovf_d = wrap | (ovf_q & ~ovf_clr_i);
    tog_d = tog_q ^ (wrap & tog_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      tog_q <= tog_d;
    end
  end

  assign ovf_o = ovf_q;
  assign tog_o = tog_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ovf_clr_i |=> ovf_q) else $error("flag lost"); // R10
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q) else $error("wrap not flagged"); // R10
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && tog_en_i |=> (tog_q != $past(tog_q))) else $error("no toggle"); // R11
  AST_TOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_en_i |=> $stable(tog_q)) else $error("toggle while disabled"); // R11
  AST_NO_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i && !wr_en_i |=> $stable(cnt_o)) else $error("count without run"); // R4
  AST_EXT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ext_sel && !wr_en_i && !mc_stb_i |=> $stable(cnt_o)) else $error("count off strobe"); // R9

endmodule

// File: tb/gtc_channel_tb.sv
module gtc_channel_tb_top;

  logic        clk;
  logic        rst_n;
  logic        mc_stb;
  logic        stb_en;
  logic        run;
  logic [3:0]  ctl;
  logic        cnt_pin;
  logic        gate_pin;
  logic        tog_en;
  logic        ovf_clr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] cnt;
  logic        ovf;
  logic        tog;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    logic [17:0] exp;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  gtc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .mc_stb_i(mc_stb), .run_i(run), .ctl_i(ctl),
    .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin), .tog_en_i(tog_en),
    .ovf_clr_i(ovf_clr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cnt_o(cnt), .ovf_o(ovf), .tog_o(tog)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Strobe: high every second clock while enabled.
  always @(negedge clk) mc_stb <= stb_en ? ~mc_stb : 1'b0;

  // Monitor: pops expected items and compares with the ports.
  initial forever begin
    @(smp_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({tog, ovf, cnt} !== it.exp) begin
        errs++;
        $display("FAIL %s: got tog=%b ovf=%b cnt=%h, expected tog=%b ovf=%b cnt=%h",
                 it.req, tog, ovf, cnt, it.exp[17], it.exp[16], it.exp[15:0]);
      end
    end
  end

  task automatic expect_now(input string req, input logic t, input logic o, input logic [15:0] c);
    item_t it;
    it.req = req;
    it.exp = {t, o, c};
    sb_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; stb_en = 1'b0; mc_stb = 1'b0; run = 1'b0; ctl = 4'b0001;
    cnt_pin = 1'b0; gate_pin = 1'b0; tog_en = 1'b1; ovf_clr = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now("R1 reset state", 0, 0, 16'h0000);

    // 16-bit timer, wrap with toggle
    load(16'hFFFD);
    expect_now("R2 load", 0, 0, 16'hFFFD);
    run = 1'b1; step(2);
    expect_now("R3 timer step", 0, 0, 16'hFFFF);
    step(1);
    expect_now("R6 wrap to zero", 1, 1, 16'h0000);
    run = 1'b0; step(2);
    expect_now("R10 flag held", 1, 1, 16'h0000);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    expect_now("R10 clear", 1, 0, 16'h0000);

    // wrap and clear in the same cycle
    load(16'hFFFF);
    run = 1'b1; ovf_clr = 1'b1; step(1);
    run = 1'b0; ovf_clr = 1'b0;
    expect_now("R10 set wins over clear", 0, 1, 16'h0000);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    expect_now("R10 later clear", 0, 0, 16'h0000);

    // 13-bit mode, toggle disabled
    ctl = 4'b0000; tog_en = 1'b0;
    load(16'h00FE);
    run = 1'b1; step(1);
    expect_now("R5 prescaler step", 0, 0, 16'h00FF);
    step(1);
    expect_now("R5 carry into high byte", 0, 0, 16'h01E0);
    run = 1'b0;
    load(16'hFFFF);
    run = 1'b1; step(1); run = 1'b0;
    expect_now("R11 no toggle when disabled / R5 wrap", 0, 1, 16'h00E0);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;

    // 8-bit reload mode
    ctl = 4'b0010; tog_en = 1'b1;
    load(16'h80FE);
    run = 1'b1; step(1);
    expect_now("R7 low byte step", 0, 0, 16'h80FF);
    step(1);
    expect_now("R7 reload from high byte", 1, 1, 16'h8080);
    step(1);
    expect_now("R7 counts on after reload", 1, 1, 16'h8081);
    run = 1'b0;
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;

    // write beats count
    ctl = 4'b0001; run = 1'b1;
    load(16'h5555);
    expect_now("R2 load beats increment", 1, 0, 16'h5555);
    step(1);
    expect_now("R3 resumes after load", 1, 0, 16'h5556);

    // hold mode
    ctl = 4'b0011; step(3);
    expect_now("R8 mode 11 holds", 1, 0, 16'h5556);

    // gate
    run = 1'b0; ctl = 4'b1001;
    load(16'h0000);
    run = 1'b1; step(4);
    expect_now("R4 gate low blocks", 1, 0, 16'h0000);
    gate_pin = 1'b1; step(2);
    expect_now("R4 gate sync latency", 1, 0, 16'h0000);
    step(1);
    expect_now("R4 gate high counts", 1, 0, 16'h0001);
    gate_pin = 1'b0; step(4);
    expect_now("R4 gate release", 1, 0, 16'h0003);
    ctl = 4'b0001; step(2);
    expect_now("R4 gate ignored when gate bit clear", 1, 0, 16'h0005);

    // counter function
    run = 1'b0; ctl = 4'b0101;
    load(16'h0000);
    stb_en = 1'b1; run = 1'b1; cnt_pin = 1'b1; step(10);
    expect_now("R9 clock ticks ignored", 1, 0, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; step(4);
      cnt_pin = 1'b1; step(4);
    end
    expect_now("R9 five falling edges", 1, 0, 16'h0005);
    cnt_pin = 1'b0; step(8);
    expect_now("R9 sixth edge", 1, 0, 16'h0006);
    stb_en = 1'b0; step(2);
    for (int i = 0; i < 3; i++) begin
      cnt_pin = 1'b1; step(4);
      cnt_pin = 1'b0; step(4);
    end
    expect_now("R9 no strobe no count", 1, 0, 16'h0006);
    stb_en = 1'b1; step(10);
    expect_now("R9 nothing pending after strobe resumes", 1, 0, 16'h0006);
    run = 1'b0; stb_en = 1'b0;
    step(2);

    done = 1;
    report();
  end

endmodule